// File: doc/BRIEF.md
# FIFO DMA Handshake Controller

This block drives the request and end-of-transfer handshake between one FIFO port of a packet buffer and an external DMA engine. When the buffer in front of the port holds data and requests are enabled, it raises a DMA request. Each read strobe that arrives while the acknowledge line is active counts as one word or byte access. The block counts accesses within the current buffer and counts completed buffers against a programmed transaction count.

The request can be released in one of two ways. In cycle-steal mode it drops for every single access. In burst mode it is held until the last access of the buffer. The end-of-transfer signal is raised either on packet events (a short packet, the last buffer of a transaction, or a zero-length packet) or on every full buffer. The active level of the request, acknowledge and end signals is set separately for each.

Configuration comes in on a write strobe that carries every field at once. A write is accepted only while the pipe select reads zero and no buffer is part-way through its accesses. The buffer fill level and the packet flags come from the surrounding FIFO logic.

Top module: `fifo_dma_hs`

## Requirements
- R1: After reset, requests are disabled and every polarity bit is 0, so `dreq_pin` and `dend_pin` both sit high (inactive, active-low).
- R2: If requests are enabled, `buf_rdy` is high, `buf_words` is nonzero and the buffer has not yet been drained, DREQ is active in the following cycle.
- R3: Polarity bit value 1 makes a line active-high and 0 makes it active-low. DREQ, DACK and DEND each use their own bit.
- R4: An access is counted only when `rd_strobe` is high, DACK is at its active level, `buf_rdy` is high, `buf_words` is nonzero and the buffer is not drained. The final access of a buffer is access number `buf_words`. The access count clears while `buf_rdy` is low.
- R5: In cycle-steal mode (burst bit 0), DREQ is inactive in the cycle of each access. It is active again in the next cycle if the buffer still holds data.
- R6: In burst mode (burst bit 1), DREQ stays active through accesses and goes inactive only in the cycle of the final access.
- R7: After the final access, DREQ stays inactive until `buf_rdy` has been low for at least one cycle.
- R8: With packet bit 0, DEND is active during the final access of a buffer whose `short_pkt` is high.
- R9: A configuration write loads the transaction count. Each final access decrements the count when it is nonzero. With packet bit 0, DEND is active during a final access made while the count is 1. A count of 0 sets no limit.
- R10: With packet bit 0, DEND is active in any cycle in which `zlp` is high and `buf_words` is 0.
- R11: With packet bit 1, DEND is active during the final access of a buffer whose `buf_words` equals DEPTH, and the short-packet, count and zero-length conditions have no effect.
- R12: A configuration write while `pipe_sel` is not 3'b000 changes nothing.
- R13: A configuration write while the current buffer has a nonzero access count changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| pipe_sel | input | 3 | Pipe select; writes are accepted only at 3'b000 |
| cfg_req_en | input | 1 | Request enable |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle steal |
| cfg_pkt_mode | input | 1 | 1 = DEND on every full buffer, 0 = packet events |
| cfg_req_pol | input | 1 | DREQ active level |
| cfg_ack_pol | input | 1 | DACK active level |
| cfg_end_pol | input | 1 | DEND active level |
| cfg_trn | input | TW | Transaction count to load |
| buf_rdy | input | 1 | Current buffer ready for reading |
| buf_words | input | $clog2(DEPTH+1) | Words held by the current buffer |
| short_pkt | input | 1 | Current buffer holds a short packet |
| zlp | input | 1 | Zero-length packet received |
| rd_strobe | input | 1 | DMA read strobe |
| dack_pin | input | 1 | DMA acknowledge, polarity per cfg_ack_pol |
| dreq_pin | output | 1 | DMA request, polarity per cfg_req_pol |
| dend_pin | output | 1 | Transfer end, polarity per cfg_end_pol |

## Verification
Buffers are run under both release modes with sizes from one word to a full buffer. This separates a request that drops on each access from one that drops only on the final access. Read strobes without an active acknowledge, and an acknowledge that is not active-high, show whether an access is counted only with a qualified acknowledge. Short packets, two-buffer transactions, zero-length events and full buffers are tried under both DEND modes, so each DEND cause is seen firing and being ignored. Writes made at a nonzero pipe select or in the middle of a buffer show that they leave the configuration untouched, and a random mix of all of these follows.

// File: rtl/fifo_dma_hs.sv
module fifo_dma_hs #(
  parameter int DEPTH = 64,
  parameter int TW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    pipe_sel,
  input  logic          cfg_req_en,
  input  logic          cfg_burst,
  input  logic          cfg_pkt_mode,
  input  logic          cfg_req_pol,
  input  logic          cfg_ack_pol,
  input  logic          cfg_end_pol,
  input  logic [TW-1:0] cfg_trn,
  input  logic          buf_rdy,
  input  logic [CW-1:0] buf_words,
  input  logic          short_pkt,
  input  logic          zlp,
  input  logic          rd_strobe,
  input  logic          dack_pin,
  output logic          dreq_pin,
  output logic          dend_pin
);

  logic          en_q, burst_q, pkt_q, rpol_q, apol_q, epol_q;
  logic [TW-1:0] trn_q;
  logic [CW-1:0] acc_q;
  logic          req_q, done_q;

  wire          cfg_ok   = cfg_we && (pipe_sel == 3'd0) && (acc_q == '0);
  wire          dack_act = apol_q ? dack_pin : !dack_pin;
  wire          live     = buf_rdy && !done_q && (buf_words != '0);
  wire          acc_ok   = rd_strobe && dack_act && live;
  wire [CW:0]   acc_inc  = {1'b0, acc_q} + (CW+1)'(1);
  wire          last     = acc_inc >= {1'b0, buf_words};
  wire          fin      = acc_ok && last;
  wire          trn_hit  = trn_q == TW'(1);
  wire          full_buf = buf_words == CW'(DEPTH);

  wire dreq_act = req_q && !(acc_ok && (!burst_q || last));
  wire dend_act = pkt_q ? (fin && full_buf)
                        : ((fin && (short_pkt || trn_hit)) || (zlp && buf_words == '0));

  assign dreq_pin = rpol_q ? dreq_act : !dreq_act;
  assign dend_pin = epol_q ? dend_act : !dend_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      burst_q <= 1'b0;
      pkt_q   <= 1'b0;
      rpol_q  <= 1'b0;
      apol_q  <= 1'b0;
      epol_q  <= 1'b0;
      trn_q   <= '0;
    end else if (cfg_ok) begin
      en_q    <= cfg_req_en;
      burst_q <= cfg_burst;
      pkt_q   <= cfg_pkt_mode;
      rpol_q  <= cfg_req_pol;
      apol_q  <= cfg_ack_pol;
      epol_q  <= cfg_end_pol;
      trn_q   <= cfg_trn;
    end else if (fin && trn_q != '0) begin
      trn_q   <= trn_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (!buf_rdy)    acc_q <= '0;
      else if (acc_ok) acc_q <= last ? '0 : acc_inc[CW-1:0];
      if (!buf_rdy)    done_q <= 1'b0;
      else if (fin)    done_q <= 1'b1;
      req_q <= en_q && buf_rdy && !(done_q || fin) && (buf_words != '0);
    end
  end

  p_req_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && live && !acc_ok) |=> req_q);

  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_rdy |=> (acc_q == '0));

  p_steal_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !burst_q) |-> !dreq_act);

  p_steal_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !last && en_q) |=> req_q);

  p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && burst_q && acc_ok && !last) |-> dreq_act);

  p_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !req_q);

  p_trn_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !cfg_ok && trn_q != '0) |=> (trn_q == $past(trn_q) - TW'(1)));

  p_cfg_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && pipe_sel != 3'd0) |=> $stable({en_q, burst_q, pkt_q, rpol_q, apol_q, epol_q, trn_q}));

  p_cfg_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != '0) |=> $stable({en_q, burst_q, pkt_q, rpol_q, apol_q, epol_q}));

endmodule

// File: tb/fifo_dma_hs_tb.sv
module fifo_dma_hs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TW = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_req_en = 0, cfg_burst = 0, cfg_pkt_mode = 0;
  logic cfg_req_pol = 0, cfg_ack_pol = 0, cfg_end_pol = 0;
  logic [2:0] pipe_sel = 0;
  logic [TW-1:0] cfg_trn = 0;
  logic buf_rdy = 0, short_pkt = 0, zlp = 0, rd_strobe = 0, dack_pin = 1;
  logic [CW-1:0] buf_words = 0;
  logic dreq_pin, dend_pin;
  logic ack = 0;

  int checks = 0, errors = 0;
  bit m_en, m_burst, m_pkt, m_rp, m_ap, m_ep, m_req, m_done;
  int m_trn, m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_dma_hs #(.DEPTH(DEPTH), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .pipe_sel(pipe_sel),
    .cfg_req_en(cfg_req_en), .cfg_burst(cfg_burst), .cfg_pkt_mode(cfg_pkt_mode),
    .cfg_req_pol(cfg_req_pol), .cfg_ack_pol(cfg_ack_pol), .cfg_end_pol(cfg_end_pol),
    .cfg_trn(cfg_trn), .buf_rdy(buf_rdy), .buf_words(buf_words), .short_pkt(short_pkt),
    .zlp(zlp), .rd_strobe(rd_strobe), .dack_pin(dack_pin),
    .dreq_pin(dreq_pin), .dend_pin(dend_pin));

  function automatic bit f_live();
    return buf_rdy && !m_done && (int'(buf_words) != 0);
  endfunction
  function automatic bit f_acc();
    return rd_strobe && ack && f_live();
  endfunction
  function automatic bit f_last();
    return (m_acc + 1) >= int'(buf_words);
  endfunction
  function automatic bit f_dreq();
    bit a;
    a = m_req && !(f_acc() && (!m_burst || f_last()));
    return m_rp ? a : !a;
  endfunction
  function automatic bit f_dend();
    bit fin, a;
    fin = f_acc() && f_last();
    if (m_pkt) a = fin && (int'(buf_words) == DEPTH);
    else a = (fin && (short_pkt || m_trn == 1)) || (zlp && int'(buf_words) == 0);
    return m_ep ? a : !a;
  endfunction
  function automatic string dend_tag();
    if (m_pkt) return "R11";
    if (zlp && int'(buf_words) == 0) return "R10";
    if (short_pkt) return "R8";
    return "R9";
  endfunction

  task automatic chk(input string tag, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_update();
    bit ok, fin;
    fin = f_acc() && f_last();
    ok = cfg_we && pipe_sel == 3'd0 && m_acc == 0;
    m_req = m_en && buf_rdy && !(m_done || fin) && (int'(buf_words) != 0);
    if (!buf_rdy) m_acc = 0;
    else if (f_acc()) m_acc = f_last() ? 0 : m_acc + 1;
    if (!buf_rdy) m_done = 0;
    else if (fin) m_done = 1;
    if (ok) begin
      m_en = cfg_req_en; m_burst = cfg_burst; m_pkt = cfg_pkt_mode;
      m_rp = cfg_req_pol; m_ap = cfg_ack_pol; m_ep = cfg_end_pol; m_trn = int'(cfg_trn);
    end else if (fin && m_trn != 0) m_trn = m_trn - 1;
  endtask

  // Called at a negedge with inputs set; compares, then advances to the next negedge.
  task automatic tick(input string ctx);
    dack_pin = m_ap ? ack : !ack;
    #1;
    chk({ctx, "/", m_burst ? "R6" : "R5", "/R2"}, "dreq_pin", dreq_pin, f_dreq());
    chk({ctx, "/", dend_tag()}, "dend_pin", dend_pin, f_dend());
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic cfg(input string ctx, input logic [2:0] ps, input bit en, input bit bu,
                     input bit pk, input bit rp, input bit ap, input bit ep, input int trn);
    cfg_we = 1; pipe_sel = ps; cfg_req_en = en; cfg_burst = bu; cfg_pkt_mode = pk;
    cfg_req_pol = rp; cfg_ack_pol = ap; cfg_end_pol = ep; cfg_trn = TW'(trn);
    tick(ctx);
    cfg_we = 0; pipe_sel = 0;
  endtask

  task automatic run_buf(input string ctx, input int words, input bit sp, input bit rnd);
    buf_rdy = 1; buf_words = CW'(words); short_pkt = sp;
    for (int i = 0; i < 6 * DEPTH + 8 && !m_done; i++) begin
      rd_strobe = rnd ? 1'($urandom % 2) : 1'b1;
      ack = rnd ? ($urandom % 4 != 0) : 1'b1;
      tick(ctx);
    end
    rd_strobe = 0; ack = 0;
    tick({ctx, "/R7"});
    tick({ctx, "/R7"});
    buf_rdy = 0; short_pkt = 0;
    tick(ctx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_en = 0; m_burst = 0; m_pkt = 0; m_rp = 0; m_ap = 0; m_ep = 0;
    m_req = 0; m_done = 0; m_trn = 0; m_acc = 0;
    chk("R1", "dreq_pin", dreq_pin, 1'b1);
    chk("R1", "dend_pin", dend_pin, 1'b1);
    tick("R1");

    buf_rdy = 1; buf_words = CW'(2);
    cfg("R12", 3'd3, 1, 0, 0, 1, 1, 1, 0);
    tick("R12");
    chk("R12", "dreq_pin stays inactive", dreq_pin, 1'b1);
    chk("R12", "dend_pin stays inactive", dend_pin, 1'b1);
    buf_rdy = 0; tick("R12");

    cfg("R3", 3'd0, 1, 0, 0, 1, 1, 0, 0);
    run_buf("R5", 3, 0, 0);
    run_buf("R5", 5, 0, 1);

    buf_rdy = 1; buf_words = CW'(4); tick("R2");
    rd_strobe = 1; ack = 0; tick("R4");
    tick("R4");
    rd_strobe = 0; buf_rdy = 0; tick("R4");

    cfg("R6", 3'd0, 1, 1, 0, 0, 0, 1, 0);
    run_buf("R6", 4, 0, 0);
    run_buf("R6", DEPTH, 0, 1);

    buf_rdy = 1; buf_words = CW'(4); tick("R13");
    rd_strobe = 1; ack = 1; tick("R13");
    rd_strobe = 0; ack = 0;
    cfg("R13", 3'd0, 1, 0, 1, 1, 1, 1, 0);
    tick("R13");
    run_buf("R13", 4, 0, 0);

    cfg("R8", 3'd0, 1, 0, 0, 1, 1, 1, 0);
    run_buf("R8", 3, 1, 0);
    cfg("R9", 3'd0, 1, 1, 0, 1, 1, 1, 2);
    run_buf("R9", DEPTH, 0, 0);
    run_buf("R9", DEPTH, 0, 1);
    run_buf("R9", DEPTH, 0, 0);

    zlp = 1; buf_words = 0; tick("R10");
    buf_rdy = 1; tick("R10");
    zlp = 0; buf_rdy = 0; tick("R10");

    cfg("R11", 3'd0, 1, 0, 1, 0, 1, 0, 1);
    run_buf("R11", DEPTH, 0, 0);
    run_buf("R11", 5, 1, 0);
    zlp = 1; buf_words = 0; tick("R11"); zlp = 0;

    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 3 == 0)
        cfg("random", ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd0, 1'($urandom % 8 != 0),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom % 4));
      zlp = ($urandom % 10 == 0);
      run_buf("random", int'($urandom % (DEPTH + 1)), 1'($urandom), 1);
      zlp = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule